// File: doc/BRIEF.md
# Bit-Serial Maximum Selector

This block finds which of several parallel input streams carries the largest unsigned word. Every stream delivers its word one bit per clock, most significant bit first, and all streams advance together. No magnitude comparators are used. Each stream has a candidate flag. In each bit cycle, a candidate showing 0 drops out if any other candidate still in the running shows 1. One OR-reduction over all streams drives the whole decision.

A word starts with a single `start` cycle that makes every stream a candidate again. The `WORD_BITS` bit cycles then follow. In the clock after the last bit edge, the block raises a one-cycle `result_valid`. With it come the index of the lowest-numbered surviving stream and a flag that says whether more than one stream reached the maximum. `start` may be raised in the same cycle as `result_valid`, so results can arrive once every `WORD_BITS + 1` clocks. The recovered maximum value itself is not produced.

Top module: `serial_max_finder`

## Requirements
- R1: After the synchronous active-high `rst`, `result_valid`, `max_index` and `tie_flag` are all 0 and no word is in progress.
- R2: A cycle with `start` high makes every stream a candidate. In each of the next `WORD_BITS` cycles, bit i of `bit_in` is taken as the current bit of stream i, most significant bit first.
- R3: A candidate whose current bit is 1 stays a candidate. A candidate whose current bit is 0 drops out exactly when some other remaining candidate shows 1. The reported index therefore always names a stream holding the largest word.
- R4: `result_valid` is high for exactly one cycle. That cycle is the one after the clock edge that samples the last bit, which is `WORD_BITS + 1` cycles after the `start` edge. A new `start` may coincide with it.
- R5: When several streams share the maximum, `max_index` reports the lowest-numbered one.
- R6: `tie_flag` is 1 with a result exactly when more than one stream holds the maximum value. This includes the case where all words are equal.
- R7: `max_index` and `tie_flag` hold their values from one result until the next result or reset.
- R8: While no word is in progress and `start` is low, `bit_in` is ignored: no result appears and the outputs do not change.
- R9: `start` raised during a word abandons that word and begins a new one. The next result depends only on the new word.
- R10: `rst` raised during a word abandons it: no result is produced for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new word; all streams become candidates |
| bit_in | input | NUM_STREAMS | Current bit of every stream, bit i for stream i |
| result_valid | output | 1 | One-cycle pulse when a result is ready |
| max_index | output | IDX_W | Lowest index of a stream holding the maximum |
| tie_flag | output | 1 | More than one stream holds the maximum |

## Verification
Several properties are checked on every cycle by assertions:
- candidate flags only ever clear during a word, and are all set after `start`;
- a stream showing 1 is never dropped, and the candidate set is never empty;
- the valid pulse is one cycle wide and never appears while idle;
- a result names the lowest surviving candidate, and its tie flag matches the number of survivors;
- the outputs hold between results.

Only the bench scenarios can show that the surviving set really is the set of largest words. For that, the bench computes the maximum arithmetically for every word combination of a four-stream, three-bit configuration. The scenarios also cover the result timing for back-to-back words, and abandoning a word through `start` or `rst`.

// File: rtl/serial_max_pkg.sv
package serial_max_pkg;

  // Width of an index able to address n items (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of a counter able to count k bit cycles (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned k);
    return (k > 1) ? $clog2(k) : 1;
  endfunction

endpackage

// File: rtl/sm_bit_sequencer.sv
module sm_bit_sequencer #(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic shift_en,
  output logic last_bit
);
  import serial_max_pkg::*;

  localparam int unsigned CNT_W = cnt_width(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0] bit_cnt;

  // A bit is consumed in every busy cycle not overridden by a new start.
  assign shift_en = busy && !start;
  assign last_bit = shift_en && (bit_cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      bit_cnt <= '0;
    end else if (busy) begin
      if (bit_cnt == LAST_CNT) begin
        busy    <= 1'b0;
        bit_cnt <= '0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R4: the counter never runs past the last bit of a word
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= LAST_CNT);

  // R9: a start always leaves a word in progress at bit zero
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && bit_cnt == '0));

endmodule

// File: rtl/sm_cand_bank.sv
module sm_cand_bank #(
  parameter int unsigned NUM_STREAMS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   shift_en,
  input  logic [NUM_STREAMS-1:0] bits,
  output logic [NUM_STREAMS-1:0] cand,
  output logic [NUM_STREAMS-1:0] cand_next,
  output logic                   any_one
);

  logic [NUM_STREAMS-1:0] live_ones;

  // Single OR-reduction across all streams: some remaining candidate shows 1.
  assign live_ones = cand & bits;
  assign any_one   = |live_ones;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    always_comb begin
      if (load)
        cand_next[s] = 1'b1;
      else if (shift_en)
        cand_next[s] = cand[s] & (bits[s] | ~any_one);
      else
        cand_next[s] = cand[s];
    end

    always_ff @(posedge clk) begin
      if (rst) cand[s] <= 1'b1;
      else     cand[s] <= cand_next[s];
    end
  end

  // R2: a start cycle makes every stream a candidate
  a_r2_load_all: assert property (@(posedge clk) disable iff (rst)
    load |=> (cand == '1));

  // R2: during a word candidate flags can only clear
  a_r2_only_clear: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load) |=> ((cand & ~$past(cand)) == '0));

  // R3: a candidate showing 1 is never dropped
  a_r3_keep_ones: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load) |=> (($past(cand) & $past(bits) & ~cand) == '0));

  // R3: at least one candidate always survives
  a_r3_nonempty: assert property (@(posedge clk) disable iff (rst)
    cand != '0);

endmodule

// File: rtl/sm_low_prio_enc.sv
module sm_low_prio_enc #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [WIDTH-1:0] req,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             multi
);

  always_comb begin
    idx   = '0;
    any   = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (req[i]) begin
        if (any) begin
          multi = 1'b1;
        end else begin
          idx = IDX_W'(i);
          any = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/serial_max_finder.sv
module serial_max_finder #(
  parameter int unsigned NUM_STREAMS = 16,
  parameter int unsigned WORD_BITS   = 8,
  parameter int unsigned IDX_W       = serial_max_pkg::idx_width(NUM_STREAMS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [NUM_STREAMS-1:0] bit_in,
  output logic                   result_valid,
  output logic [IDX_W-1:0]       max_index,
  output logic                   tie_flag
);

  logic                   busy;
  logic                   shift_en;
  logic                   last_bit;
  logic [NUM_STREAMS-1:0] cand;
  logic [NUM_STREAMS-1:0] cand_next;
  logic                   any_one;
  logic [IDX_W-1:0]       enc_idx;
  logic                   enc_any;
  logic                   enc_multi;

  sm_bit_sequencer #(.WORD_BITS(WORD_BITS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .shift_en (shift_en),
    .last_bit (last_bit)
  );

  sm_cand_bank #(.NUM_STREAMS(NUM_STREAMS)) u_cand (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .shift_en  (shift_en),
    .bits      (bit_in),
    .cand      (cand),
    .cand_next (cand_next),
    .any_one   (any_one)
  );

  // Encode the set that the last bit edge will leave behind, so the
  // result is registered in the same edge as the final candidate set.
  sm_low_prio_enc #(.WIDTH(NUM_STREAMS), .IDX_W(IDX_W)) u_enc (
    .req   (cand_next),
    .idx   (enc_idx),
    .any   (enc_any),
    .multi (enc_multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      max_index    <= '0;
      tie_flag     <= 1'b0;
    end else begin
      result_valid <= last_bit;
      if (last_bit) begin
        max_index <= enc_idx;
        tie_flag  <= enc_multi;
      end
    end
  end

  logic [NUM_STREAMS-1:0] below_mask;
  always_comb begin
    below_mask = ({{(NUM_STREAMS-1){1'b0}}, 1'b1} << max_index) - 1'b1;
  end

  // R4: the result strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R5: the reported stream survived and none below it did
  a_r5_index_lowest: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (cand[max_index] && ((cand & below_mask) == '0)));

  // R6: tie flag agrees with the number of survivors
  a_r6_tie_matches: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (tie_flag == ($countones(cand) > 1)));

  // R7: outputs hold between results
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> ($stable(max_index) && $stable(tie_flag)));

  // R8: no result can follow an idle cycle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !result_valid);

  // R3: a surviving candidate set exists whenever a result is encoded
  a_r3_enc_nonempty: assert property (@(posedge clk) disable iff (rst)
    last_bit |-> enc_any);

endmodule

// File: tb/serial_max_finder_bench.sv
module serial_max_finder_bench;

  localparam int N = 4;
  localparam int K = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  bit_in = '0;
  logic          result_valid;
  logic [IW-1:0] max_index;
  logic          tie_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  serial_max_finder #(.NUM_STREAMS(N), .WORD_BITS(K)) u_serial_max_finder (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .bit_in       (bit_in),
    .result_valid (result_valid),
    .max_index    (max_index),
    .tie_flag     (tie_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Column b of word w: bit b of each stream's value.
  function automatic logic [N-1:0] column(input int w, input int b);
    logic [N-1:0] c;
    for (int i = 0; i < N; i++) c[i] = 1'(((w >> (K * i)) >> b) & 1);
    return c;
  endfunction

  // Present one full word, starting at a negative edge; ends at the
  // negative edge where the result is visible.
  task automatic run_word(input int w);
    int mx, lo, cnt;
    mx = -1; lo = 0; cnt = 0;
    for (int i = 0; i < N; i++) begin
      int v;
      v = (w >> (K * i)) & ((1 << K) - 1);
      if (v > mx) begin mx = v; lo = i; cnt = 1; end
      else if (v == mx) cnt++;
    end
    start = 1'b1;
    for (int b = K - 1; b >= 0; b--) begin
      @(negedge clk);
      chk(result_valid == 1'b0, "R4 early valid", int'(result_valid), 0);
      start  = 1'b0;
      bit_in = column(w, b);
    end
    @(negedge clk);
    chk(result_valid == 1'b1, "R4 valid", int'(result_valid), 1);
    chk(int'(max_index) == lo, "R3/R5 index", int'(max_index), lo);
    chk(tie_flag == (cnt > 1), "R6 tie", int'(tie_flag), int'(cnt > 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(result_valid == 1'b0, "R1 valid", int'(result_valid), 0);
    chk(max_index == '0, "R1 index", int'(max_index), 0);
    chk(tie_flag == 1'b0, "R1 tie", int'(tie_flag), 0);

    // R8 idle inputs ignored
    for (int c = 0; c < 6; c++) begin
      bit_in = N'(c * 5 + 3);
      @(negedge clk);
      chk(result_valid == 1'b0, "R8 idle valid", int'(result_valid), 0);
      chk(max_index == '0 && !tie_flag, "R8 idle outputs", int'(max_index), 0);
    end

    // R2 R3 R4 R5 R6: every combination, back to back
    for (int w = 0; w < (1 << (N * K)); w++) run_word(w);
    start = 1'b0;

    // R7 hold after the last word (all streams 7: index 0, tie)
    for (int c = 0; c < 4; c++) begin
      bit_in = N'(c);
      @(negedge clk);
      chk(result_valid == 1'b0, "R7 valid", int'(result_valid), 0);
      chk(max_index == 2'd0 && tie_flag, "R7 hold", int'(max_index), 0);
    end

    // A distinct result so the hold check sees a non-zero index
    run_word(6 << (K * 2));  // stream 2 = 6, rest 0 -> index 2
    start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      bit_in = '1;
      @(negedge clk);
      chk(max_index == 2'd2 && !tie_flag, "R7 hold idx2", int'(max_index), 2);
    end

    // R9 restart: partial word favouring stream 3, then stream 1 wins
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; bit_in = 4'b1000;
    @(negedge clk);
    chk(result_valid == 1'b0, "R9 partial", int'(result_valid), 0);
    bit_in = 4'b1000;
    run_word(5 << K);  // only stream 1 non-zero
    chk(max_index == 2'd1, "R9 restart index", int'(max_index), 1);
    start = 1'b0;

    // R10 reset mid-word
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; bit_in = 4'b0100;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < K + 2; c++) begin
      @(negedge clk);
      chk(result_valid == 1'b0, "R10 no valid", int'(result_valid), 0);
      chk(max_index == '0 && !tie_flag, "R10 cleared", int'(max_index), 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule